// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two thresholds used by a FIFO's programmable flags: an empty-side offset and a full-side offset. It presents both on output ports for the flag comparators. While master reset is held, the pins are sampled to pick one of eight default offset values and the method used to load new offsets. The same pins also capture a parallel-mapping option and a read-mode bit.

After reset, one pin (`ofs_access`) switches the write and read strobes from the FIFO storage to the offset registers. In serial mode, every enabled write shifts one bit from `mode_si` into the offsets. In parallel mode, every enabled write takes one whole offset from the write data bus. Enabled reads return the offsets one after another on `rd_data`. A partial reset restarts the load and read-back sequences and keeps everything that was configured.

Top module: `ofs_prog_unit`

## Requirements
- R1: While `mrst_n` is low, both offsets take a default chosen by the index {`ofs_access`, `flag_sel[1]`, `flag_sel[0]`}. Index 0 gives 7, 1 gives 31, 2 gives 63, 3 gives 127, 4 gives 255, 5 gives 511, 6 gives 1023 and 7 gives 15. Master reset also clears `rd_data` and `rd_valid`.
- R2: If `ofs_access` is high during master reset, parallel loading is selected and `prog_serial` is 0. If it is low, serial loading is selected and `prog_serial` is 1. The method holds until the next master reset.
- R3: In parallel mode, writes with `ofs_access` high load the empty offset first and the full offset second. The next write after that loads the empty offset again.
- R4: In parallel mode with the parity option off, the loaded offset is `wr_data[15:0]`. With the option on (`ipar_sel` high at master reset), the loaded offset is {`wr_data[16:9]`, `wr_data[7:0]`}, and bits 8 and 17 are dropped.
- R5: In serial mode, each write with `ofs_access` high stores `mode_si` into the next bit, least significant bit first. Bits 0 to 15 go to the empty offset, then bits 0 to 15 go to the full offset. The next write after that starts again at bit 0 of the empty offset. No more than one offset bit changes per clock.
- R6: While `ofs_access` is low, `wr_en` and `rd_en` change neither offset nor `rd_data`, and `rd_valid` stays 0.
- R7: A read with `ofs_access` high puts an offset on `rd_data` in the following cycle, empty first and then full, alternating. `rd_valid` is 1 in that cycle only. The format is the zero-extended offset when the parity option is off, and {0, ofs[15:8], 0, ofs[7:0]} when it is on.
- R8: A low `prst_n` keeps both offsets, the loading method, the parity option and `ft_mode`. It returns the next write and the next read to the empty offset (serial bit 0) and clears `rd_data` and `rd_valid`.
- R9: `ft_mode` equals `mode_si` as sampled during master reset and holds until the next master reset.
- R10: In serial mode, the contents of `wr_data` have no effect. In parallel mode, `mode_si` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; samples the configuration pins |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ofs_access | input | 1 | At reset: default index MSB and method select; afterwards: routes strobes to the offsets |
| flag_sel | input | 2 | Default index low bits, sampled at reset |
| mode_si | input | 1 | At reset: read-mode select; afterwards: serial data bit |
| ipar_sel | input | 1 | Parity mapping option, sampled at reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Parallel offset data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Offset read-back data |
| rd_valid | output | 1 | Read-back data valid |
| empty_ofs | output | OFS_W | Empty-side offset |
| full_ofs | output | OFS_W | Full-side offset |
| prog_serial | output | 1 | 1 when serial loading is selected |
| ft_mode | output | 1 | Read mode latched at reset |

## Verification
The bench steps through all eight default indices. A wrong table entry, or a swapped select bit, shows up as a wrong offset immediately after reset. It loads more than 32 serial bits, so a counter that does not wrap into the empty offset corrupts the full offset, and an MSB-first shifter produces bit-reversed values. It writes parallel words with bits 8 and 17 set, so a design that keeps those bits in parity mode, or drops them when parity is off, reports the wrong offset. Partial reset is applied in the middle of a serial load, and strobes are issued with `ofs_access` low, so a design that clears the offsets on partial reset or lets FIFO traffic reach the offsets is exposed.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    typedef enum logic {
        PROG_SERIAL   = 1'b0,
        PROG_PARALLEL = 1'b1
    } prog_meth_e;

    localparam int unsigned DFLT_IDX_W = 3;

    // Default offset selected at master reset
    function automatic logic [31:0] dflt_offset(input logic [DFLT_IDX_W-1:0] idx);
        logic [31:0] v;
        case (idx)
            3'd0:    v = 32'd7;
            3'd1:    v = 32'd31;
            3'd2:    v = 32'd63;
            3'd3:    v = 32'd127;
            3'd4:    v = 32'd255;
            3'd5:    v = 32'd511;
            3'd6:    v = 32'd1023;
            default: v = 32'd15;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ofs_dflt_sel.sv
module ofs_dflt_sel
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  logic [DFLT_IDX_W-1:0] idx,
    output logic [OFS_W-1:0]      value
);
    logic [31:0] full_v;

    always_comb begin
        full_v = dflt_offset(idx);
        value  = full_v[OFS_W-1:0];
    end
endmodule

// File: rtl/ofs_bus_unpack.sv
module ofs_bus_unpack #(
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic [DATA_W-1:0]                      bus,
    input  logic                                   ipar,
    output logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  ofs
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int PW     = BYTE_W - 1;
    localparam int OFS_W  = NBYTES * PW;

    logic [OFS_W-1:0] squeezed;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign squeezed[b*PW +: PW] = bus[b*BYTE_W +: PW];
    end

    assign ofs = ipar ? squeezed : bus[OFS_W-1:0];
endmodule

// File: rtl/ofs_bus_pack.sv
module ofs_bus_pack #(
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  ofs,
    input  logic                                   ipar,
    output logic [DATA_W-1:0]                      bus
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int PW     = BYTE_W - 1;
    localparam int SPAN_W = NBYTES * BYTE_W;

    logic [SPAN_W-1:0] spread;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign spread[b*BYTE_W +: BYTE_W] = {1'b0, ofs[b*PW +: PW]};
    end

    assign bus = ipar ? DATA_W'(spread) : DATA_W'(ofs);
endmodule

// File: rtl/ofs_prog_unit.sv
module ofs_prog_unit
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                                   clk,
    input  logic                                   mrst_n,
    input  logic                                   prst_n,
    input  logic                                   ofs_access,
    input  logic [1:0]                             flag_sel,
    input  logic                                   mode_si,
    input  logic                                   ipar_sel,
    input  logic                                   wr_en,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   rd_en,
    output logic [DATA_W-1:0]                      rd_data,
    output logic                                   rd_valid,
    output logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  empty_ofs,
    output logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  full_ofs,
    output logic                                   prog_serial,
    output logic                                   ft_mode
);
    localparam int OFS_W = (DATA_W / BYTE_W) * (BYTE_W - 1);
    localparam int CNT_W = $clog2(2 * OFS_W);
    localparam int IDX_W = $clog2(OFS_W);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OFS_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * OFS_W - 1);

    typedef struct packed {
        logic [OFS_W-1:0]  e_ofs;
        logic [OFS_W-1:0]  f_ofs;
        prog_meth_e        meth;
        logic              ipar;
        logic              ft;
        logic              wsel;
        logic [CNT_W-1:0]  bcnt;
        logic              rsel;
        logic [DATA_W-1:0] rdat;
        logic              rvld;
    } st_t;

    st_t st_d, st_q;

    logic [OFS_W-1:0]  dflt_val;
    logic [OFS_W-1:0]  par_val;
    logic [OFS_W-1:0]  rd_src;
    logic [DATA_W-1:0] rd_bus;
    logic [CNT_W-1:0]  sidx;

    ofs_dflt_sel #(.OFS_W(OFS_W)) dflt_i (
        .idx   ({ofs_access, flag_sel}),
        .value (dflt_val)
    );

    ofs_bus_unpack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) unpack_i (
        .bus  (wr_data),
        .ipar (st_q.ipar),
        .ofs  (par_val)
    );

    assign rd_src = st_q.rsel ? st_q.f_ofs : st_q.e_ofs;

    ofs_bus_pack #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) pack_i (
        .ofs  (rd_src),
        .ipar (st_q.ipar),
        .bus  (rd_bus)
    );

    always_comb begin
        st_d = st_q;
        st_d.rvld = 1'b0;
        sidx = (st_q.bcnt < CNT_HALF) ? st_q.bcnt : st_q.bcnt - CNT_HALF;

        if (!mrst_n) begin
            st_d.e_ofs = dflt_val;
            st_d.f_ofs = dflt_val;
            st_d.meth  = ofs_access ? PROG_PARALLEL : PROG_SERIAL;
            st_d.ipar  = ipar_sel;
            st_d.ft    = mode_si;
            st_d.wsel  = 1'b0;
            st_d.bcnt  = '0;
            st_d.rsel  = 1'b0;
            st_d.rdat  = '0;
        end else if (!prst_n) begin
            st_d.wsel  = 1'b0;
            st_d.bcnt  = '0;
            st_d.rsel  = 1'b0;
            st_d.rdat  = '0;
        end else begin
            if (ofs_access && rd_en) begin
                st_d.rdat = rd_bus;
                st_d.rsel = ~st_q.rsel;
                st_d.rvld = 1'b1;
            end
            if (ofs_access && wr_en) begin
                if (st_q.meth == PROG_PARALLEL) begin
                    if (st_q.wsel) begin
                        st_d.f_ofs = par_val;
                    end else begin
                        st_d.e_ofs = par_val;
                    end
                    st_d.wsel = ~st_q.wsel;
                end else begin
                    if (st_q.bcnt < CNT_HALF) begin
                        st_d.e_ofs[sidx[IDX_W-1:0]] = mode_si;
                    end else begin
                        st_d.f_ofs[sidx[IDX_W-1:0]] = mode_si;
                    end
                    st_d.bcnt = (st_q.bcnt == CNT_LAST) ? '0 : st_q.bcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data     = st_q.rdat;
    assign rd_valid    = st_q.rvld;
    assign empty_ofs   = st_q.e_ofs;
    assign full_ofs    = st_q.f_ofs;
    assign prog_serial = (st_q.meth == PROG_SERIAL);
    assign ft_mode     = st_q.ft;
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
    parameter int DATA_W = 18,
    parameter int BYTE_W = 9
) (
    input logic                                   clk,
    input logic                                   mrst_n,
    input logic                                   prst_n,
    input logic                                   ofs_access,
    input logic                                   wr_en,
    input logic                                   rd_en,
    input logic                                   rd_valid,
    input logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  empty_ofs,
    input logic [(DATA_W/BYTE_W)*(BYTE_W-1)-1:0]  full_ofs,
    input logic                                   prog_serial,
    input logic                                   ft_mode
);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !(ofs_access && wr_en) |=> $stable(empty_ofs) && $stable(full_ofs));

    // R8
    prst_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> $stable(empty_ofs) && $stable(full_ofs)
                    && $stable(prog_serial) && $stable(ft_mode));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (prst_n && ofs_access && rd_en) |=> rd_valid);

    // R7
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !(prst_n && ofs_access && rd_en) |=> !rd_valid);

    // R5
    one_bit_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (prog_serial && prst_n && ofs_access && wr_en)
        |=> $countones({empty_ofs, full_ofs} ^ $past({empty_ofs, full_ofs})) <= 1);

    // R2
    meth_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(prog_serial));

    // R9
    ft_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> $stable(ft_mode));
endmodule

bind ofs_prog_unit ofs_prog_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
    .clk         (clk),
    .mrst_n      (mrst_n),
    .prst_n      (prst_n),
    .ofs_access  (ofs_access),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs),
    .prog_serial (prog_serial),
    .ft_mode     (ft_mode)
);

// File: tb/ofs_prog_unit_tb.sv
module ofs_prog_unit_tb_top;
    localparam int DW = 18;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          mrst_n, prst_n, ofs_access, mode_si, ipar_sel, wr_en, rd_en;
    logic [1:0]    flag_sel;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          rd_valid, prog_serial, ft_mode;
    logic [OW-1:0] empty_ofs, full_ofs;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    bit    mvalid = 0;
    string cur_req = "R1";

    // reference model state
    logic [OW-1:0] m_e, m_f;
    logic [DW-1:0] m_rdat;
    bit            m_par, m_ipar, m_ft, m_wsel, m_rsel, m_rvld;
    int            m_bcnt;

    always #10 clk = ~clk;

    ofs_prog_unit dut_i (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ofs_access(ofs_access),
        .flag_sel(flag_sel), .mode_si(mode_si), .ipar_sel(ipar_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .prog_serial(prog_serial), .ft_mode(ft_mode)
    );

    function automatic int dtab(input int idx);
        case (idx)
            0: return 7;    1: return 31;   2: return 63;   3: return 127;
            4: return 255;  5: return 511;  6: return 1023; default: return 15;
        endcase
    endfunction

    function automatic logic [OW-1:0] unpk(input logic [DW-1:0] d, input bit ip);
        if (ip) return {d[16:9], d[7:0]};
        return d[15:0];
    endfunction

    function automatic logic [DW-1:0] pk(input logic [OW-1:0] v, input bit ip);
        if (ip) return {1'b0, v[15:8], 1'b0, v[7:0]};
        return {2'b00, v};
    endfunction

    always @(posedge clk) begin
        if (!mrst_n) begin
            m_e = OW'(dtab({ofs_access, flag_sel}));
            m_f = m_e;
            m_par = ofs_access; m_ipar = ipar_sel; m_ft = mode_si;
            m_wsel = 0; m_bcnt = 0; m_rsel = 0; m_rdat = '0; m_rvld = 0;
            mvalid = 1;
        end else if (!prst_n) begin
            m_wsel = 0; m_bcnt = 0; m_rsel = 0; m_rdat = '0; m_rvld = 0;
        end else begin
            m_rvld = 0;
            if (ofs_access && rd_en) begin
                m_rdat = pk(m_rsel ? m_f : m_e, m_ipar);
                m_rsel = !m_rsel;
                m_rvld = 1;
            end
            if (ofs_access && wr_en) begin
                if (m_par) begin
                    if (m_wsel) m_f = unpk(wr_data, m_ipar);
                    else        m_e = unpk(wr_data, m_ipar);
                    m_wsel = !m_wsel;
                end else begin
                    if (m_bcnt < OW) m_e[m_bcnt] = mode_si;
                    else             m_f[m_bcnt-OW] = mode_si;
                    m_bcnt = (m_bcnt + 1) % (2 * OW);
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mvalid && !done) begin
            chk(cur_req, "empty_ofs",   32'(empty_ofs),   32'(m_e));
            chk(cur_req, "full_ofs",    32'(full_ofs),    32'(m_f));
            chk(cur_req, "rd_data",     32'(rd_data),     32'(m_rdat));
            chk(cur_req, "rd_valid",    32'(rd_valid),    32'(m_rvld));
            chk(cur_req, "prog_serial", 32'(prog_serial), 32'(!m_par));
            chk(cur_req, "ft_mode",     32'(ft_mode),     32'(m_ft));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_mrst(input bit acc, input logic [1:0] sel, input bit si, input bit ip);
        wr_en = 0; rd_en = 0; mrst_n = 0;
        ofs_access = acc; flag_sel = sel; mode_si = si; ipar_sel = ip;
        tick(); tick();
        mrst_n = 1; ofs_access = 0; flag_sel = 2'b00; mode_si = 0; ipar_sel = 0;
        tick();
    endtask

    task automatic ser_bit(input bit b, input logic [DW-1:0] junk);
        ofs_access = 1; wr_en = 1; mode_si = b; wr_data = junk;
        tick();
        wr_en = 0;
    endtask

    task automatic par_wr(input logic [DW-1:0] d, input bit si);
        ofs_access = 1; wr_en = 1; wr_data = d; mode_si = si;
        tick();
        wr_en = 0;
    endtask

    task automatic rd_one();
        ofs_access = 1; rd_en = 1;
        tick();
        rd_en = 0;
    endtask

    initial begin
        mrst_n = 0; prst_n = 1; ofs_access = 0; flag_sel = 2'b10; mode_si = 1;
        ipar_sel = 0; wr_en = 0; rd_en = 0; wr_data = '0;

        // R1 R2 R9: reset into serial mode, index 2
        cur_req = "R1";
        do_mrst(1'b0, 2'b10, 1'b1, 1'b0);
        chk("R1", "default idx2", 32'(empty_ofs), 32'd63);
        chk("R2", "serial method", 32'(prog_serial), 32'd1);
        chk("R9", "ft latched", 32'(ft_mode), 32'd1);

        // R5 R10: serial load 0x1234 then 0xBEEF with bus noise
        cur_req = "R5";
        for (int i = 0; i < 32; i++) begin
            logic [31:0] w;
            w = 32'hBEEF_1234;
            ser_bit(w[i], DW'(18'h3FFFF ^ i));
        end
        chk("R5", "serial empty", 32'(empty_ofs), 32'h1234);
        chk("R10", "serial full, bus ignored", 32'(full_ofs), 32'hBEEF);
        ser_bit(1'b1, '1); ser_bit(1'b0, '1); ser_bit(1'b1, '0);
        chk("R5", "serial wrap", 32'(empty_ofs), 32'h1235);

        // R8: partial reset mid-sequence
        cur_req = "R8";
        prst_n = 0; tick(); prst_n = 1;
        chk("R8", "offset kept", 32'(full_ofs), 32'hBEEF);
        chk("R8", "method kept", 32'(prog_serial), 32'd1);
        ser_bit(1'b0, '0);
        chk("R8", "restart at bit0", 32'(empty_ofs), 32'h1234);

        // R7: read back
        cur_req = "R7";
        rd_one();
        chk("R7", "read empty", 32'(rd_data), 32'h1234);
        chk("R7", "valid", 32'(rd_valid), 32'd1);
        rd_one();
        chk("R7", "read full", 32'(rd_data), 32'hBEEF);
        tick();
        chk("R7", "valid drops", 32'(rd_valid), 32'd0);

        // R6: strobes without access
        cur_req = "R6";
        ofs_access = 0; wr_en = 1; rd_en = 1; mode_si = 1; wr_data = '1;
        repeat (4) tick();
        wr_en = 0; rd_en = 0;
        chk("R6", "empty untouched", 32'(empty_ofs), 32'h1234);
        chk("R6", "rd_data held", 32'(rd_data), 32'hBEEF);
        chk("R6", "no valid", 32'(rd_valid), 32'd0);

        // R1 R2 R9: parallel, parity on, index 5
        cur_req = "R2";
        do_mrst(1'b1, 2'b01, 1'b0, 1'b1);
        chk("R1", "default idx5", 32'(full_ofs), 32'd511);
        chk("R2", "parallel method", 32'(prog_serial), 32'd0);
        chk("R9", "ft low", 32'(ft_mode), 32'd0);

        // R3 R4 R10: parallel writes, parity mapping, wrap
        cur_req = "R4";
        par_wr({1'b1, 8'hA5, 1'b1, 8'h5A}, 1'b1);
        chk("R4", "parity squeeze", 32'(empty_ofs), 32'hA55A);
        par_wr({1'b0, 8'h0F, 1'b1, 8'h0F}, 1'b0);
        chk("R3", "second to full", 32'(full_ofs), 32'h0F0F);
        cur_req = "R3";
        par_wr({1'b1, 8'h11, 1'b1, 8'h11}, 1'b1);
        chk("R3", "wrap to empty", 32'(empty_ofs), 32'h1111);
        chk("R10", "serial pin ignored", 32'(full_ofs), 32'h0F0F);
        cur_req = "R7";
        rd_one();
        chk("R7", "parity readback", 32'(rd_data), 32'h2211);
        rd_one();
        chk("R7", "parity readback full", 32'(rd_data), 32'h1E0F);

        // R4: parity off keeps low 16 bits
        cur_req = "R4";
        do_mrst(1'b1, 2'b11, 1'b0, 1'b0);
        chk("R1", "default idx7", 32'(empty_ofs), 32'd15);
        par_wr(18'h3_5678, 1'b0);
        chk("R4", "plain low bits", 32'(empty_ofs), 32'h5678);

        // R1 R2: sweep all defaults
        cur_req = "R1";
        for (int k = 0; k < 8; k++) begin
            do_mrst(k[2], k[1:0], 1'b0, 1'b0);
            chk("R1", "default sweep", 32'(empty_ofs), 32'(dtab(k)));
            chk("R2", "method sweep", 32'(prog_serial), 32'(!k[2]));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule